// File: doc/BRIEF.md
# Double-Column Hit Trigger Primitive

This block lives inside a pixel readout chip and turns the per-column hit counts of one bunch crossing into compact trigger primitives. A qualified input word carries one hit count for each double column. A double column is marked as hit when its count is strictly above a programmable pixel threshold. The block then forms two sums for that crossing: the number of hit double columns, and the number of clusters. A cluster is a maximal run of adjacent hit double columns.

Each sum is compared with its own programmable cut, which gives two pass flags. A third flag reports high double-column multiplicity. The primitives are registered and appear one cycle after the input, with a matching valid strobe. A new crossing may arrive on every cycle. The cut registers reset to loose values and can be reloaded between crossings to tighter values, for example 8 and 4.

Top module: `dctp_top`

## Requirements
- R1: Column i's count sits at bits [5i+4:5i] of `col_counts`. A column is hit only when its count is strictly greater than the pixel threshold. A count equal to the threshold is not hit.
- R2: `dc_sum` equals the number of hit columns and saturates at 31 instead of wrapping.
- R3: `cl_sum` equals the number of maximal runs of adjacent hit columns. A run begins at column 0 if column 0 is hit, and at any column i that is hit while column i-1 is not. `cl_sum` also saturates at 31.
- R4: `dc_pass` is 1 exactly when `dc_sum` is at least the hit-column cut. `cl_pass` is 1 exactly when `cl_sum` is at least the cluster cut.
- R5: `high_mult` is 1 exactly when `dc_sum` is at least the high-multiplicity threshold.
- R6: After reset the settings are: pixel threshold 0, hit-column cut 2, cluster cut 2, high-multiplicity threshold 4. All outputs are 0.
- R7: A settings load (`cfg_load` high) takes effect only in a cycle where `in_valid` is low. A load presented together with `in_valid` is ignored.
- R8: Each cycle with `in_valid` high gives `out_valid` high on the next cycle, together with that crossing's primitives. Back-to-back crossings give back-to-back results. `out_valid` is low after any cycle without input, and the primitive outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks a crossing's counts as present |
| col_counts | input | 130 | 26 packed 5-bit hit counts, column 0 at the least significant end |
| cfg_load | input | 1 | Load the four settings below |
| cfg_pix_thr | input | 5 | Pixel hit threshold |
| cfg_dc_cut | input | 5 | Hit-column cut |
| cfg_cl_cut | input | 5 | Cluster cut |
| cfg_hm_thr | input | 5 | High-multiplicity threshold |
| out_valid | output | 1 | Primitives below belong to the previous cycle's crossing |
| dc_sum | output | 5 | Hit double-column count |
| cl_sum | output | 5 | Cluster count |
| dc_pass | output | 1 | Hit-column cut passed |
| cl_pass | output | 1 | Cluster cut passed |
| high_mult | output | 1 | High multiplicity flag |

## Verification
The block keeps no history from one crossing to the next, apart from its settings. A fault in the hit map or the run-start logic therefore shows up in the very next `out_valid` cycle as a wrong `dc_sum` or `cl_sum`. The patterns used are runs at either edge, isolated columns and counts equal to the threshold, so such faults reach the ports. A corrupted setting is different: it stays silent until a crossing lands near that cut. For this reason the bench places sums exactly on each cut and one below it, and it checks a load that must be ignored through the crossing that follows it.

// File: rtl/dctp_pkg.sv
// Shared sizing for the double-column trigger primitive.
// Assumes SUM_W is wide enough that the saturation value is meaningful.
package dctp_pkg;
    localparam int NUM_DC = 26;  // double columns per chip
    localparam int CNT_W  = 5;   // bits of one per-column hit count
    localparam int SUM_W  = 5;   // bits of each primitive sum
endpackage

// File: rtl/dctp_cfg.sv
// Settings registers for the trigger primitive.
// Loads only between crossings (in_valid low); resets to the loose cuts.
module dctp_cfg #(
    parameter int CNT_W = 5,
    parameter int SUM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             cfg_load,
    input  logic [CNT_W-1:0] cfg_pix_thr,
    input  logic [SUM_W-1:0] cfg_dc_cut,
    input  logic [SUM_W-1:0] cfg_cl_cut,
    input  logic [SUM_W-1:0] cfg_hm_thr,
    output logic [CNT_W-1:0] pix_thr,
    output logic [SUM_W-1:0] dc_cut,
    output logic [SUM_W-1:0] cl_cut,
    output logic [SUM_W-1:0] hm_thr
);
    localparam logic [SUM_W-1:0] DEF_DC_CUT = SUM_W'(2);
    localparam logic [SUM_W-1:0] DEF_CL_CUT = SUM_W'(2);
    localparam logic [SUM_W-1:0] DEF_HM_THR = SUM_W'(4);

    logic take;
    assign take = cfg_load && !in_valid;

    // Hold settings; accept a load only in a cycle without a crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_thr <= '0;
            dc_cut  <= DEF_DC_CUT;
            cl_cut  <= DEF_CL_CUT;
            hm_thr  <= DEF_HM_THR;
        end else if (take) begin
            pix_thr <= cfg_pix_thr;
            dc_cut  <= cfg_dc_cut;
            cl_cut  <= cfg_cl_cut;
            hm_thr  <= cfg_hm_thr;
        end
    end

    AST_CFG_HELD_IN_CROSSING: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($stable(pix_thr) && $stable(dc_cut) && $stable(cl_cut) && $stable(hm_thr))); // R7
endmodule

// File: rtl/dctp_hitmap.sv
// Per-column hit comparison and cluster-start detection.
// Assumes column i occupies bits [CNT_W*i +: CNT_W] of the packed input.
module dctp_hitmap #(
    parameter int NUM_DC = 26,
    parameter int CNT_W  = 5
) (
    input  logic [NUM_DC*CNT_W-1:0] col_counts,
    input  logic [CNT_W-1:0]        pix_thr,
    output logic [NUM_DC-1:0]       hit,
    output logic [NUM_DC-1:0]       start
);
    for (genvar i = 0; i < NUM_DC; i++) begin : g_col
        // Column is hit only when strictly above threshold.
        assign hit[i] = col_counts[CNT_W*i +: CNT_W] > pix_thr;
        if (i == 0) begin : g_edge
            // Leftmost column starts a run whenever it is hit.
            assign start[i] = hit[i];
        end else begin : g_inner
            // Run starts where the left neighbour is unhit.
            assign start[i] = hit[i] && !hit[i-1];
        end
    end

    always_comb begin
        AST_START_IMPLIES_HIT: assert ((start & ~hit) == '0); // R3
    end
endmodule

// File: rtl/dctp_satcount.sv
// Saturating population count of a flag vector.
// Assumes a purely combinational use; result clamps at all ones.
module dctp_satcount #(
    parameter int N     = 26,
    parameter int SUM_W = 5
) (
    input  logic [N-1:0]     flags,
    output logic [SUM_W-1:0] total
);
    localparam int WIDE_W = $clog2(N + 1) + 1;
    localparam logic [WIDE_W-1:0] MAXV = WIDE_W'((1 << SUM_W) - 1);

    logic [WIDE_W-1:0] raw;

    // Count set flags at full width.
    always_comb begin
        raw = '0;
        for (int k = 0; k < N; k++) raw = raw + WIDE_W'(flags[k]);
    end

    // Clamp to the output width.
    always_comb begin
        if (raw > MAXV) total = '1;
        else            total = raw[SUM_W-1:0];
    end
endmodule

// File: rtl/dctp_top.sv
// Double-column hit trigger primitive: hit map, two saturating sums,
// cut comparisons and a one-cycle output register per crossing.
// Assumes a crossing may arrive every cycle and settings change between them.
module dctp_top #(
    parameter int NUM_DC = dctp_pkg::NUM_DC,
    parameter int CNT_W  = dctp_pkg::CNT_W,
    parameter int SUM_W  = dctp_pkg::SUM_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [NUM_DC*CNT_W-1:0] col_counts,
    input  logic                    cfg_load,
    input  logic [CNT_W-1:0]        cfg_pix_thr,
    input  logic [SUM_W-1:0]        cfg_dc_cut,
    input  logic [SUM_W-1:0]        cfg_cl_cut,
    input  logic [SUM_W-1:0]        cfg_hm_thr,
    output logic                    out_valid,
    output logic [SUM_W-1:0]        dc_sum,
    output logic [SUM_W-1:0]        cl_sum,
    output logic                    dc_pass,
    output logic                    cl_pass,
    output logic                    high_mult
);
    logic [CNT_W-1:0]  pix_thr;
    logic [SUM_W-1:0]  dc_cut, cl_cut, hm_thr;
    logic [NUM_DC-1:0] hit, start;
    logic [SUM_W-1:0]  dc_next, cl_next;

    dctp_cfg #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_load(cfg_load),
        .cfg_pix_thr(cfg_pix_thr), .cfg_dc_cut(cfg_dc_cut),
        .cfg_cl_cut(cfg_cl_cut), .cfg_hm_thr(cfg_hm_thr),
        .pix_thr(pix_thr), .dc_cut(dc_cut), .cl_cut(cl_cut), .hm_thr(hm_thr)
    );

    dctp_hitmap #(.NUM_DC(NUM_DC), .CNT_W(CNT_W)) u_map (
        .col_counts(col_counts), .pix_thr(pix_thr), .hit(hit), .start(start)
    );

    dctp_satcount #(.N(NUM_DC), .SUM_W(SUM_W)) u_dc_cnt (
        .flags(hit), .total(dc_next)
    );

    dctp_satcount #(.N(NUM_DC), .SUM_W(SUM_W)) u_cl_cnt (
        .flags(start), .total(cl_next)
    );

    // Strobe marking a fresh result, one cycle after each crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the sums and flags of each crossing; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc_sum    <= '0;
            cl_sum    <= '0;
            dc_pass   <= 1'b0;
            cl_pass   <= 1'b0;
            high_mult <= 1'b0;
        end else if (in_valid) begin
            dc_sum    <= dc_next;
            cl_sum    <= cl_next;
            dc_pass   <= dc_next >= dc_cut;
            cl_pass   <= cl_next >= cl_cut;
            high_mult <= dc_next >= hm_thr;
        end
    end

    AST_VALID_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
    AST_CLUSTERS_LE_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cl_sum <= dc_sum)); // R3
    AST_EMPTY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((dc_sum == '0) == (cl_sum == '0))); // R2
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dc_sum) && $stable(cl_sum))); // R8
endmodule

// File: tb/sim_dctp_top.sv
// Directed bench for the double-column trigger primitive.
module sim_dctp_top;
    localparam int N = 26;
    localparam int CW = 5;
    localparam int SW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [N*CW-1:0] col_counts = '0;
    logic cfg_load = 1'b0;
    logic [CW-1:0] cfg_pix_thr = '0;
    logic [SW-1:0] cfg_dc_cut = '0, cfg_cl_cut = '0, cfg_hm_thr = '0;
    logic out_valid, dc_pass, cl_pass, high_mult;
    logic [SW-1:0] dc_sum, cl_sum;

    int total = 0;
    int bad = 0;

    // Bench copy of the settings, as the requirements define them.
    int m_thr = 0, m_dcc = 2, m_clc = 2, m_hm = 4;
    int cnt [N];

    always #2 clk = ~clk;

    dctp_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .col_counts(col_counts),
        .cfg_load(cfg_load), .cfg_pix_thr(cfg_pix_thr), .cfg_dc_cut(cfg_dc_cut),
        .cfg_cl_cut(cfg_cl_cut), .cfg_hm_thr(cfg_hm_thr), .out_valid(out_valid),
        .dc_sum(dc_sum), .cl_sum(cl_sum), .dc_pass(dc_pass), .cl_pass(cl_pass),
        .high_mult(high_mult)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [N*CW-1:0] pack();
        logic [N*CW-1:0] v = '0;
        for (int i = 0; i < N; i++) v[i*CW +: CW] = CW'(cnt[i]);
        return v;
    endfunction

    // Send one crossing and check every primitive one cycle later.
    task automatic crossing(string tag);
        int e_dc = 0, e_cl = 0;
        bit prev = 0;
        for (int i = 0; i < N; i++) begin
            bit h = cnt[i] > m_thr;
            if (h) e_dc++;
            if (h && !prev) e_cl++;
            prev = h;
        end
        if (e_dc > 31) e_dc = 31;
        if (e_cl > 31) e_cl = 31;
        @(negedge clk);
        in_valid = 1'b1;
        col_counts = pack();
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R8 valid"}, int'(out_valid), 1);
        check({tag, " R1 R2 dc_sum"}, int'(dc_sum), e_dc);
        check({tag, " R3 cl_sum"}, int'(cl_sum), e_cl);
        check({tag, " R4 dc_pass"}, int'(dc_pass), int'(e_dc >= m_dcc));
        check({tag, " R4 cl_pass"}, int'(cl_pass), int'(e_cl >= m_clc));
        check({tag, " R5 high_mult"}, int'(high_mult), int'(e_dc >= m_hm));
    endtask

    task automatic load(int thr, int dcc, int clc, int hm);
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_pix_thr = CW'(thr); cfg_dc_cut = SW'(dcc);
        cfg_cl_cut = SW'(clc); cfg_hm_thr = SW'(hm);
        @(negedge clk);
        cfg_load = 1'b0;
        m_thr = thr; m_dcc = dcc; m_clc = clc; m_hm = hm;
    endtask

    task automatic clear_cnt();
        for (int i = 0; i < N; i++) cnt[i] = 0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 out_valid", int'(out_valid), 0);
        check("R6 dc_sum", int'(dc_sum), 0);
        check("R6 cl_sum", int'(cl_sum), 0);
        check("R6 flags", int'({dc_pass, cl_pass, high_mult}), 0);
    endtask

    task automatic t_defaults();
        // R6: threshold 0 -> count 1 hits; cuts 2/2/4 at boundaries.
        clear_cnt(); cnt[0] = 1; crossing("R6 one col");
        clear_cnt(); cnt[3] = 1; cnt[7] = 2; crossing("R6 two iso");
        clear_cnt(); cnt[10] = 1; cnt[11] = 1; cnt[12] = 1; cnt[20] = 3; crossing("R6 hm edge");
        clear_cnt(); crossing("R6 empty");
    endtask

    task automatic t_edges();
        // R3: runs touching both ends and alternating columns.
        clear_cnt(); cnt[0] = 5; cnt[1] = 5; cnt[24] = 5; cnt[25] = 5; crossing("R3 ends");
        clear_cnt(); for (int i = 0; i < N; i += 2) cnt[i] = 9; crossing("R3 alternate");
        clear_cnt(); for (int i = 0; i < N; i++) cnt[i] = 31; crossing("R2 all hit");
    endtask

    task automatic t_threshold();
        // R1: equal to threshold is not a hit.
        load(7, 2, 2, 4);
        clear_cnt(); cnt[2] = 7; cnt[3] = 8; cnt[5] = 8; cnt[6] = 6; crossing("R1 strict");
    endtask

    task automatic t_tight();
        // R4 R5: tighter cuts placed on and below the sums.
        load(0, 8, 4, 8);
        clear_cnt(); for (int i = 0; i < 8; i++) cnt[i * 3] = 2; crossing("R4 on cut");
        clear_cnt(); for (int i = 0; i < 7; i++) cnt[i * 3] = 2; crossing("R4 below cut");
    endtask

    task automatic t_ignored_load();
        // R7: load with a crossing is dropped; next crossing keeps old cuts.
        clear_cnt(); cnt[1] = 1; cnt[4] = 1;
        @(negedge clk);
        in_valid = 1'b1; col_counts = pack();
        cfg_load = 1'b1; cfg_pix_thr = 5'd20; cfg_dc_cut = 5'd1;
        cfg_cl_cut = 5'd1; cfg_hm_thr = 5'd1;
        @(negedge clk);
        in_valid = 1'b0; cfg_load = 1'b0;
        check("R7 same-cycle dc", int'(dc_sum), 2);
        check("R7 same-cycle pass", int'(dc_pass), 0);
        crossing("R7 after ignored");
    endtask

    task automatic t_back_to_back();
        // R8: consecutive crossings, then an idle cycle holds values.
        clear_cnt(); cnt[0] = 1; cnt[1] = 1; cnt[2] = 1;
        @(negedge clk);
        in_valid = 1'b1; col_counts = pack();
        clear_cnt(); cnt[9] = 1; cnt[15] = 1;
        @(negedge clk);
        check("R8 first valid", int'(out_valid), 1);
        check("R8 first dc", int'(dc_sum), 3);
        col_counts = pack();
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 second dc", int'(dc_sum), 2);
        check("R8 second cl", int'(cl_sum), 2);
        @(negedge clk);
        check("R8 idle valid", int'(out_valid), 0);
        check("R8 idle hold", int'(dc_sum), 2);
    endtask

    initial begin
        t_reset();
        t_defaults();
        t_edges();
        t_threshold();
        t_tight();
        t_ignored_load();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule